// File: doc/BRIEF.md
# Cyclic-Prefix Symbol Timing Correlator

This block recovers OFDM symbol timing from the redundancy in the cyclic prefix. Each accepted complex sample is multiplied by the conjugate of the sample that arrived one FFT length earlier. The products are summed over a sliding window as long as the prefix. The two window energies, one over the current samples and one over the lagged samples, are summed in the same way. All three sums are maintained recursively. On each accepted sample the term that enters the window is added and the term that leaves it is subtracted, so one update reads four stored samples no matter how long the window is.

The block splits the stream into symbols of a fixed length, counted from the first sample after reset. Within each symbol it finds the sample position where the correlation power |r|² is largest. At the end of the symbol it reports that position, the power, the energy product ds0·ds1 at that point, and a trigger flag. The flag tells whether the normalized metric |r|²/(ds0·ds1) reached a programmable threshold. The normalized metric equals one for a clean repetition, and noise or interference lower it. The raw correlation and the live energy product are also exported, so that downstream logic can reject peaks that occur in low-energy stretches.

Top module: `cp_timing_correlator`

## Requirements
- R1: While reset is held, and just after it is released, corr_re, corr_im and corr_div are zero, pk_valid is low, and pk_idx, pk_pow, pk_div and pk_trig are zero.
- R2: One clock after a sample is accepted (in_valid high at a rising edge), corr_re + j·corr_im equals the sum over the last WIN accepted samples x[k] of x[k]·conj(x[k−LAG]). Samples older than the first one after reset count as zero. When in_valid is low, the correlation keeps its value.
- R3: In the same cycle, corr_div equals ds0·ds1. Here ds0 is the summed |x[k]|² over the last WIN samples, and ds1 is the same sum over the samples LAG earlier.
- R4: Sample positions run from 0 to SYM−1 and wrap, starting with the first accepted sample after reset. For each symbol, pk_idx is the position with the largest |r|². On a tie, the earliest position wins.
- R5: pk_valid is a single-cycle pulse. It rises two clocks after the last sample of a symbol is accepted and carries pk_idx, pk_pow = |r|² and pk_div = ds0·ds1 at the chosen position.
- R6: pk_trig is 1 exactly when the divisor at the peak is nonzero and |r|²·2^TF ≥ thr·ds0·ds1. The threshold thr is an unsigned value with TF fraction bits.
- R7: When the lagged copy of the window is an exact repetition, the reported power equals the reported divisor (metric of one). With thr = 2^TF the trigger is set.
- R8: The correlation power never exceeds the energy product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample accepted this cycle |
| in_re | input | DW | Real part of sample, signed |
| in_im | input | DW | Imaginary part of sample, signed |
| thr | input | TF+1 | Trigger threshold, TF fraction bits |
| corr_re | output | AW | Real part of windowed correlation, signed |
| corr_im | output | AW | Imaginary part of windowed correlation, signed |
| corr_div | output | 2·AW | Live product of the two window energies |
| pk_valid | output | 1 | Per-symbol peak report strobe |
| pk_idx | output | clog2(SYM) | Position of the peak within the symbol |
| pk_pow | output | 2·AW | Correlation power at the peak |
| pk_div | output | 2·AW | Energy product at the peak |
| pk_trig | output | 1 | Metric at the peak reached the threshold |

## Verification
The hardest case to reach from the ports is a peak that must land at a known position in the middle of a symbol, with an exact repetition that drives the metric to one. The stimulus gets there in three steps. It feeds a prefix of unrelated samples so that the prefix structure straddles a symbol boundary. It then copies the tail of each symbol body into its prefix, and checks both the reported position and the equality of power and divisor. Ties are forced with a constant input, which makes every fully filled window identical, and with silence, which makes the divisor zero. Idle gaps between samples show that the sums hold their values and that the report timing follows accepted samples rather than clock cycles.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
   // accumulator width for a window of win products of dw-bit samples
   function automatic int acc_width(input int dw, input int win);
      return 2 * dw + 1 + $clog2(win + 1);
   endfunction
endpackage

// File: rtl/cpc_delay_line.sv
module cpc_delay_line #(
   parameter int DW  = 12,
   parameter int LAG = 2048,
   parameter int WIN = 416
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic signed [DW-1:0] din_re,
   input  logic signed [DW-1:0] din_im,
   output logic signed [DW-1:0] tap_re [3],
   output logic signed [DW-1:0] tap_im [3]
);
   localparam int DEPTH = LAG + WIN;
   localparam int PW    = $clog2(DEPTH);
   localparam int FW    = $clog2(DEPTH + 1);

   logic signed [DW-1:0] mem_re [DEPTH];
   logic signed [DW-1:0] mem_im [DEPTH];
   logic [PW-1:0]        wp;
   logic [FW-1:0]        fill;

   function automatic logic [PW-1:0] back(input logic [PW-1:0] p, input int d);
      int t;
      t = int'(p) - d;
      if (t < 0) t = t + DEPTH;
      return PW'(t);
   endfunction

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_re[wp] <= din_re;
         mem_im[wp] <= din_im;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         fill <= '0;
      end else if (wr_en) begin
         wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         if (fill != FW'(DEPTH)) fill <= fill + 1'b1;
      end
   end

   // tap 0: one lag back, tap 1: one window back, tap 2: both
   for (genvar g = 0; g < 3; g++) begin : g_tap
      localparam int D = (g == 0) ? LAG : (g == 1) ? WIN : LAG + WIN;
      logic ok;
      assign ok        = (fill >= FW'(D));
      assign tap_re[g] = ok ? mem_re[back(wp, D)] : '0;
      assign tap_im[g] = ok ? mem_im[back(wp, D)] : '0;
   end

   a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FW'(DEPTH));
endmodule

// File: rtl/cpc_window_acc.sv
module cpc_window_acc #(
   parameter int DW  = 12,
   parameter int WIN = 416,
   parameter int AW  = cpc_pkg::acc_width(DW, WIN)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 v,
   input  logic signed [DW-1:0] x_re,
   input  logic signed [DW-1:0] x_im,
   input  logic signed [DW-1:0] l_re,
   input  logic signed [DW-1:0] l_im,
   input  logic signed [DW-1:0] w_re,
   input  logic signed [DW-1:0] w_im,
   input  logic signed [DW-1:0] f_re,
   input  logic signed [DW-1:0] f_im,
   output logic signed [AW-1:0] r_re,
   output logic signed [AW-1:0] r_im,
   output logic signed [AW-1:0] e0,
   output logic signed [AW-1:0] e1,
   output logic                 sum_v
);
   localparam int PW = 2 * DW + 1;

   function automatic logic signed [PW-1:0] mul_re(
      input logic signed [DW-1:0] a_re, input logic signed [DW-1:0] a_im,
      input logic signed [DW-1:0] b_re, input logic signed [DW-1:0] b_im);
      return PW'(a_re) * PW'(b_re) + PW'(a_im) * PW'(b_im);
   endfunction

   function automatic logic signed [PW-1:0] mul_im(
      input logic signed [DW-1:0] a_re, input logic signed [DW-1:0] a_im,
      input logic signed [DW-1:0] b_re, input logic signed [DW-1:0] b_im);
      return PW'(a_im) * PW'(b_re) - PW'(a_re) * PW'(b_im);
   endfunction

   logic signed [PW-1:0] in_cr, in_ci, out_cr, out_ci;
   logic signed [PW-1:0] in_e0, out_e0, in_e1, out_e1;

   assign in_cr  = mul_re(x_re, x_im, l_re, l_im);
   assign in_ci  = mul_im(x_re, x_im, l_re, l_im);
   assign out_cr = mul_re(w_re, w_im, f_re, f_im);
   assign out_ci = mul_im(w_re, w_im, f_re, f_im);
   assign in_e0  = mul_re(x_re, x_im, x_re, x_im);
   assign out_e0 = mul_re(w_re, w_im, w_re, w_im);
   assign in_e1  = mul_re(l_re, l_im, l_re, l_im);
   assign out_e1 = mul_re(f_re, f_im, f_re, f_im);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_re  <= '0;
         r_im  <= '0;
         e0    <= '0;
         e1    <= '0;
         sum_v <= 1'b0;
      end else begin
         sum_v <= v;
         if (v) begin
            r_re <= r_re + AW'(in_cr) - AW'(out_cr);
            r_im <= r_im + AW'(in_ci) - AW'(out_ci);
            e0   <= e0 + AW'(in_e0) - AW'(out_e0);
            e1   <= e1 + AW'(in_e1) - AW'(out_e1);
         end
      end
   end

   a_r3_energy_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
      !e0[AW-1] && !e1[AW-1]);
   a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !v |=> ($stable(r_re) && $stable(r_im)));
endmodule

// File: rtl/cpc_peak_search.sv
module cpc_peak_search #(
   parameter int AW  = 34,
   parameter int SYM = 2560,
   parameter int TF  = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         v,
   input  logic signed [AW-1:0]         r_re,
   input  logic signed [AW-1:0]         r_im,
   input  logic signed [AW-1:0]         e0,
   input  logic signed [AW-1:0]         e1,
   input  logic [TF:0]                  thr,
   output logic [2*AW-1:0]              live_div,
   output logic                         pk_valid,
   output logic [$clog2(SYM)-1:0]       pk_idx,
   output logic [2*AW-1:0]              pk_pow,
   output logic [2*AW-1:0]              pk_div,
   output logic                         pk_trig
);
   localparam int P2 = 2 * AW;
   localparam int IW = $clog2(SYM);
   localparam int CW = P2 + TF + 1;

   logic signed [P2-1:0] sq_re, sq_im;
   logic [P2-1:0]        pow, div, e0u, e1u;
   logic [CW-1:0]        lhs, rhs;
   logic                 trig;

   assign sq_re = P2'(r_re) * P2'(r_re);
   assign sq_im = P2'(r_im) * P2'(r_im);
   assign pow   = $unsigned(sq_re) + $unsigned(sq_im);
   assign e0u   = P2'($unsigned(e0));
   assign e1u   = P2'($unsigned(e1));
   assign div   = e0u * e1u;
   assign lhs   = CW'(pow) << TF;
   assign rhs   = CW'(thr) * CW'(div);
   assign trig  = (div != '0) && (lhs >= rhs);
   assign live_div = div;

   logic [IW-1:0] pos, b_idx, n_idx;
   logic [P2-1:0] b_pow, b_div, n_pow, n_div;
   logic          b_trig, n_trig, take, last;

   assign last   = (pos == IW'(SYM - 1));
   assign take   = (pos == '0) || (pow > b_pow);
   assign n_idx  = take ? pos  : b_idx;
   assign n_pow  = take ? pow  : b_pow;
   assign n_div  = take ? div  : b_div;
   assign n_trig = take ? trig : b_trig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos      <= '0;
         b_idx    <= '0;
         b_pow    <= '0;
         b_div    <= '0;
         b_trig   <= 1'b0;
         pk_valid <= 1'b0;
         pk_idx   <= '0;
         pk_pow   <= '0;
         pk_div   <= '0;
         pk_trig  <= 1'b0;
      end else begin
         pk_valid <= v && last;
         if (v) begin
            pos    <= last ? '0 : pos + 1'b1;
            b_idx  <= n_idx;
            b_pow  <= n_pow;
            b_div  <= n_div;
            b_trig <= n_trig;
            if (last) begin
               pk_idx  <= n_idx;
               pk_pow  <= n_pow;
               pk_div  <= n_div;
               pk_trig <= n_trig;
            end
         end
      end
   end

   a_r8_power_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pow <= div);
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pk_valid |=> !pk_valid);
   a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      pk_valid |-> (pk_idx <= IW'(SYM - 1)));
   a_r6_trig_needs_energy: assert property (@(posedge clk) disable iff (!rst_n)
      (pk_valid && pk_trig) |-> (pk_div != '0));
endmodule

// File: rtl/cp_timing_correlator.sv
module cp_timing_correlator #(
   parameter int DW  = 12,
   parameter int LAG = 2048,
   parameter int WIN = 416,
   parameter int SYM = 2560,
   parameter int TF  = 16,
   localparam int AW = cpc_pkg::acc_width(DW, WIN),
   localparam int IW = $clog2(SYM)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_re,
   input  logic signed [DW-1:0] in_im,
   input  logic [TF:0]          thr,
   output logic signed [AW-1:0] corr_re,
   output logic signed [AW-1:0] corr_im,
   output logic [2*AW-1:0]      corr_div,
   output logic                 pk_valid,
   output logic [IW-1:0]        pk_idx,
   output logic [2*AW-1:0]      pk_pow,
   output logic [2*AW-1:0]      pk_div,
   output logic                 pk_trig
);
   if (DW < 2) begin : g_bad_dw
      $error("sample width too small");
   end
   if (WIN < 1 || WIN >= LAG) begin : g_bad_win
      $error("window must be shorter than the lag");
   end
   if (SYM < LAG + WIN) begin : g_bad_sym
      $error("symbol shorter than lag plus window");
   end

   logic signed [DW-1:0] tap_re [3];
   logic signed [DW-1:0] tap_im [3];
   logic signed [AW-1:0] e0, e1;
   logic                 sum_v;

   cpc_delay_line #(.DW(DW), .LAG(LAG), .WIN(WIN)) u_dly (
      .clk(clk), .rst_n(rst_n), .wr_en(in_valid),
      .din_re(in_re), .din_im(in_im),
      .tap_re(tap_re), .tap_im(tap_im)
   );

   cpc_window_acc #(.DW(DW), .WIN(WIN), .AW(AW)) u_acc (
      .clk(clk), .rst_n(rst_n), .v(in_valid),
      .x_re(in_re), .x_im(in_im),
      .l_re(tap_re[0]), .l_im(tap_im[0]),
      .w_re(tap_re[1]), .w_im(tap_im[1]),
      .f_re(tap_re[2]), .f_im(tap_im[2]),
      .r_re(corr_re), .r_im(corr_im), .e0(e0), .e1(e1), .sum_v(sum_v)
   );

   cpc_peak_search #(.AW(AW), .SYM(SYM), .TF(TF)) u_pk (
      .clk(clk), .rst_n(rst_n), .v(sum_v),
      .r_re(corr_re), .r_im(corr_im), .e0(e0), .e1(e1), .thr(thr),
      .live_div(corr_div), .pk_valid(pk_valid), .pk_idx(pk_idx),
      .pk_pow(pk_pow), .pk_div(pk_div), .pk_trig(pk_trig)
   );
endmodule

// File: tb/cp_timing_correlator_tb.sv
module cp_timing_correlator_tb;
   localparam int CLK_P = 10;
   localparam int DW = 8, LAG = 64, WIN = 16, SYM = 80, TF = 8;
   localparam int AW = cpc_pkg::acc_width(DW, WIN);
   localparam int IW = $clog2(SYM);

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
   logic signed [DW-1:0] in_re = '0, in_im = '0;
   logic [TF:0] thr = '0;
   logic signed [AW-1:0] corr_re, corr_im;
   logic [2*AW-1:0] corr_div, pk_pow, pk_div;
   logic pk_valid, pk_trig;
   logic [IW-1:0] pk_idx;

   always #(CLK_P/2) clk = ~clk;

   cp_timing_correlator #(.DW(DW), .LAG(LAG), .WIN(WIN), .SYM(SYM), .TF(TF)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
      .thr(thr), .corr_re(corr_re), .corr_im(corr_im), .corr_div(corr_div),
      .pk_valid(pk_valid), .pk_idx(pk_idx), .pk_pow(pk_pow), .pk_div(pk_div),
      .pk_trig(pk_trig)
   );

   int nchk = 0, nfail = 0;
   int hr [0:1023];
   int hi [0:1023];
   int nsamp = 0;
   longint m_re, m_im, m_pow, m_div;
   bit m_trig;
   int b_idx; longint b_pow, b_div; bit b_trig;
   bit pend; int x_idx; longint x_pow, x_div; bit x_trig;
   int l_idx; longint l_pow, l_div; bit l_trig;
   int seed = 7;

   task automatic chk(input string req, input longint act, input longint exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int rnd();
      seed = seed * 1103515245 + 12345;
      return ((seed >>> 16) & 255) - 128;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      nsamp = 0; m_re = 0; m_im = 0; m_pow = 0; m_div = 0; m_trig = 0;
      pend = 0; l_idx = -1;
   endtask

   task automatic observe();
      if (pend) begin
         chk("R5 pk_valid pulse", longint'(pk_valid), 1);
         chk("R4 pk_idx", longint'(pk_idx), x_idx);
         chk("R5 pk_pow", longint'(pk_pow), x_pow);
         chk("R5 pk_div", longint'(pk_div), x_div);
         chk("R6 pk_trig", longint'(pk_trig), longint'(x_trig));
         l_idx = pk_idx; l_pow = pk_pow; l_div = pk_div; l_trig = pk_trig;
         pend = 0;
      end else begin
         chk("R5 pk_valid idle", longint'(pk_valid), 0);
      end
   endtask

   task automatic push(input int re, input int im);
      int n, pos;
      @(negedge clk);
      in_valid = 1'b1; in_re = DW'(re); in_im = DW'(im);
      hr[nsamp] = re; hi[nsamp] = im; nsamp++;
      n = nsamp - 1; pos = n % SYM;
      m_re = 0; m_im = 0;
      begin
         longint s0, s1;
         s0 = 0; s1 = 0;
         for (int k = 0; k < WIN; k++) begin
            int ia, ib, ar, ai, br, bi;
            ia = n - k; ib = ia - LAG;
            ar = (ia >= 0) ? hr[ia] : 0; ai = (ia >= 0) ? hi[ia] : 0;
            br = (ib >= 0) ? hr[ib] : 0; bi = (ib >= 0) ? hi[ib] : 0;
            m_re += longint'(ar) * br + longint'(ai) * bi;
            m_im += longint'(ai) * br - longint'(ar) * bi;
            s0 += longint'(ar) * ar + longint'(ai) * ai;
            s1 += longint'(br) * br + longint'(bi) * bi;
         end
         m_div = s0 * s1;
      end
      m_pow = m_re * m_re + m_im * m_im;
      m_trig = (m_div != 0) && ((m_pow << TF) >= longint'(thr) * m_div);
      if (pos == 0 || m_pow > b_pow) begin
         b_idx = pos; b_pow = m_pow; b_div = m_div; b_trig = m_trig;
      end
      @(posedge clk); #1;
      chk("R2 corr_re", longint'(corr_re), m_re);
      chk("R2 corr_im", longint'(corr_im), m_im);
      chk("R3 corr_div", longint'(corr_div), m_div);
      observe();
      if (pos == SYM - 1) begin
         pend = 1; x_idx = b_idx; x_pow = b_pow; x_div = b_div; x_trig = b_trig;
      end
   endtask

   task automatic idle(input int cyc);
      for (int c = 0; c < cyc; c++) begin
         @(negedge clk);
         in_valid = 1'b0;
         @(posedge clk); #1;
         chk("R2 hold re", longint'(corr_re), m_re);
         chk("R2 hold im", longint'(corr_im), m_im);
         observe();
      end
   endtask

   // one prefixed symbol: CP of WIN samples copies the last WIN of LAG body samples
   task automatic cp_symbol(input int noise, input int gap);
      int br [0:LAG-1];
      int bi [0:LAG-1];
      for (int k = 0; k < LAG; k++) begin br[k] = rnd() / 2; bi[k] = rnd() / 2; end
      for (int k = 0; k < WIN; k++) begin
         push(br[LAG-WIN+k] + ((noise != 0) ? rnd() % noise : 0),
              bi[LAG-WIN+k] + ((noise != 0) ? rnd() % noise : 0));
         if (gap > 0) idle(gap);
      end
      for (int k = 0; k < LAG; k++) begin
         push(br[k], bi[k]);
         if (gap > 0) idle(gap);
      end
   endtask

   task automatic t_reset();
      @(negedge clk); rst_n = 1'b0;
      #1;
      chk("R1 corr_re in reset", longint'(corr_re), 0);
      chk("R1 pk_valid in reset", longint'(pk_valid), 0);
      do_reset();
      #1;
      chk("R1 corr_im", longint'(corr_im), 0);
      chk("R1 corr_div", longint'(corr_div), 0);
      chk("R1 pk_idx", longint'(pk_idx), 0);
      chk("R1 pk_pow", longint'(pk_pow), 0);
      chk("R1 pk_trig", longint'(pk_trig), 0);
   endtask

   task automatic t_clean_offset();
      thr = 9'd256;
      do_reset();
      for (int k = 0; k < 30; k++) push(rnd(), rnd());
      for (int s = 0; s < 3; s++) cp_symbol(0, 0);
      idle(3);
      // last report covers samples 160..239; repetition ends at sample 189 -> position 29
      chk("R4 mid-symbol peak index", l_idx, 29);
      chk("R7 ideal power equals divisor", l_pow, l_div);
      chk("R7 ideal trigger at unity", longint'(l_trig), 1);
   endtask

   task automatic t_noisy(input int th);
      thr = 9'(th);
      do_reset();
      for (int k = 0; k < 10; k++) push(rnd(), rnd());
      for (int s = 0; s < 2; s++) cp_symbol(24, 0);
      idle(3);
   endtask

   task automatic t_silence();
      thr = 9'd1;
      do_reset();
      for (int k = 0; k < SYM; k++) push(0, 0);
      idle(3);
      chk("R4 tie on silence picks first", l_idx, 0);
      chk("R6 zero divisor no trigger", longint'(l_trig), 0);
      chk("R5 silence power", l_pow, 0);
   endtask

   task automatic t_constant();
      thr = 9'd256;
      do_reset();
      for (int k = 0; k < 2 * SYM; k++) push(10, 0);
      idle(3);
      chk("R4 equal full windows pick position 0", l_idx, 0);
      chk("R7 constant repetition", l_pow, l_div);
   endtask

   task automatic t_gaps();
      thr = 9'd200;
      do_reset();
      cp_symbol(0, 2);
      for (int k = 0; k < SYM - LAG - WIN; k++) begin push(rnd(), rnd()); idle(1); end
      idle(3);
      chk("R4 gapped stream peak at end of repetition", l_idx, LAG + WIN - 1);
   endtask

   initial begin
      #(CLK_P * 150000);
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      t_reset();
      t_clean_offset();
      t_noisy(250);
      t_noisy(128);
      t_silence();
      t_constant();
      t_gaps();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule